// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block drives the strobes and the shared address/data lines of a microcontroller's external memory bus. It counts oscillator clocks through a 12-clock machine cycle and, from the request sampled at the start of each machine cycle, produces the address-latch pulse, the code-read strobe, the data read and write strobes, the two address bytes and the direction of the low byte lines. It also captures the byte returned by memory.

The address-latch pulse keeps a steady rate in every machine cycle, even when no external access takes place. An external code cycle reads two consecutive bytes, one in each half of the machine cycle. A data cycle gives up the second latch pulse and both code-read strobes. In their place it asserts a single long read or write strobe. The high address byte comes either from the full 16-bit data address or from the port register, depending on the address width of the request.

The block is meant to sit between a processor core's bus unit and the pins. An external transparent latch, clocked by the address-latch pulse, holds the low address byte.

Top module: `ext_bus_seq`

## Requirements
- R1: Clocks in a machine cycle are numbered 0 to 11. Phase 0 is the first clock after the request is sampled. `ale` is high in phases 0-1 and 6-7 of every idle and code machine cycle, so each pulse lasts 2 clocks and the rate is one pulse per 6 clocks.
- R2: Requests are sampled on the clock edge that ends phase 11. `data_req` takes priority over `fetch_ext`. During and right after a synchronous reset, `ale`=0, `psen_n`=`rd_n`=`wr_n`=1, `bus_lo_oe`=0 and `rdata_valid`=0. The first phase 0 follows the first edge after reset is released.
- R3: In a code machine cycle (`fetch_ext`=1, `data_req`=0), `psen_n` is low in phases 3-5 and 9-11. This is one clock after `ale` falls, for 3 clocks. In every other kind of cycle it stays high.
- R4: A code machine cycle presents `fetch_addr` in its first half and `fetch_addr`+1 in its second half. The increment carries into the high byte and wraps from FFFFh to 0000h.
- R5: A data machine cycle (`data_req`=1) has `ale` high only in phases 0-1, and `psen_n` stays high throughout.
- R6: In a data cycle, `rd_n` (`data_we`=0) or `wr_n` (`data_we`=1) is low in phases 5-10. That is 6 clocks, starting 3 clocks after `ale` falls. Only one of `psen_n`, `rd_n`, `wr_n` is low at any time.
- R7: `bus_hi_out` carries `data_addr[15:8]` when `data_wide`=1. When `data_wide`=0 it carries the `port_hi` value captured at the sampling edge. In idle cycles it follows `port_hi` directly.
- R8: `bus_lo_oe`=1 with the low address byte on `bus_lo_out` only while `ale` is high. The lines are released from the clock after `ale` falls until `psen_n` or `rd_n` rises. On a write, `wr_data` is driven in phases 2-11, which covers the whole `wr_n` pulse.
- R9: `rdata` takes `bus_lo_in` on the edge at which `psen_n` or `rd_n` goes high. `rdata_valid` is 1 for the single clock after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_ext | input | 1 | Next machine cycle is an external code read |
| fetch_addr | input | 16 | Address of the first code byte |
| data_req | input | 1 | Next machine cycle is an external data access |
| data_we | input | 1 | 1 = data write, 0 = data read |
| data_wide | input | 1 | 1 = 16-bit data address, 0 = 8-bit |
| data_addr | input | 16 | Data address |
| wr_data | input | 8 | Byte to write |
| port_hi | input | 8 | High-byte port register contents |
| bus_lo_in | input | 8 | Low byte lines as read from the pins |
| bus_lo_out | output | 8 | Low byte lines, drive value |
| bus_lo_oe | output | 1 | Low byte lines drive enable |
| bus_hi_out | output | 8 | High address byte lines |
| ale | output | 1 | Address latch pulse, active high |
| psen_n | output | 1 | Code read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| rdata | output | 8 | Captured read byte |
| rdata_valid | output | 1 | One-clock flag for a newly captured byte |

## Verification
The bench builds the block with its defaults: a 12-clock machine cycle, 6-clock halves, 16-bit addresses and 8-bit data. With these values, a code fetch at 12FFh carries into the high byte, and a fetch at FFFFh wraps to 0000h. Both the 16-bit and the 8-bit data address forms, and reads and writes, can be run back to back with fetches. Every phase of every cycle kind is compared against the expected pin pattern. A memory model that latches the low byte on the address-latch pulse returns the read data, so the capture edge is also checked.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

    // bus geometry
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int HI_W   = ADDR_W - DATA_W;

    // machine cycle geometry, in oscillator clocks
    localparam int MC_CLKS   = 12;
    localparam int HALF_CLKS = MC_CLKS / 2;
    localparam int ALE_CLKS  = 2;
    localparam int CODE_GAP  = 1;   // ale fall to code strobe
    localparam int DATA_GAP  = 3;   // ale fall to data strobe
    localparam int STB_CLKS  = 6;   // data strobe width

    localparam int PH_W = $clog2(MC_CLKS);

    // derived windows (inclusive)
    localparam int CODE_FIRST = ALE_CLKS + CODE_GAP;
    localparam int CODE_LAST  = HALF_CLKS - 1;
    localparam int STB_FIRST  = ALE_CLKS + DATA_GAP;
    localparam int STB_LAST   = STB_FIRST + STB_CLKS - 1;
    localparam int WD_FIRST   = ALE_CLKS;
    localparam int WD_LAST    = MC_CLKS - 1;

    typedef logic [PH_W-1:0] phase_t;

    typedef enum logic [1:0] {
        CK_IDLE  = 2'd0,
        CK_FETCH = 2'd1,
        CK_DRD   = 2'd2,
        CK_DWR   = 2'd3
    } cyc_kind_t;

    typedef struct packed {
        cyc_kind_t         kind;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } cyc_req_t;

    function automatic logic is_data(input cyc_kind_t k);
        return (k == CK_DRD) || (k == CK_DWR);
    endfunction

    function automatic logic in_win(input phase_t p, input int lo, input int hi);
        return (int'(p) >= lo) && (int'(p) <= hi);
    endfunction

endpackage

// File: rtl/ebs_phase_gen.sv
module ebs_phase_gen
    import ebs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_t ph,
    output phase_t hph,
    output logic   upper,
    output logic   wrap
);

    phase_t ph_q;

    // reset parks the counter on the last phase so the first edge after
    // release samples a request and opens phase 0
    always_ff @(posedge clk) begin
        if (rst)       ph_q <= phase_t'(MC_CLKS - 1);
        else if (wrap) ph_q <= '0;
        else           ph_q <= ph_q + phase_t'(1);
    end

    always_comb begin
        wrap  = in_win(ph_q, MC_CLKS - 1, MC_CLKS - 1);
        upper = in_win(ph_q, HALF_CLKS, MC_CLKS - 1);
        hph   = upper ? (ph_q - phase_t'(HALF_CLKS)) : ph_q;
        ph    = ph_q;
    end

endmodule

// File: rtl/ebs_req_latch.sv
module ebs_req_latch
    import ebs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wrap,
    input  logic              fetch_ext,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              data_req,
    input  logic              data_we,
    input  logic              data_wide,
    input  logic [ADDR_W-1:0] data_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [HI_W-1:0]   port_hi,
    output cyc_req_t          req
);

    cyc_req_t nxt;

    // data access wins over a code read in the same machine cycle
    always_comb begin
        nxt = '{kind: CK_IDLE, addr: '0, wdata: '0};
        if (data_req) begin
            nxt.kind  = data_we ? CK_DWR : CK_DRD;
            nxt.addr  = {data_wide ? data_addr[ADDR_W-1:DATA_W] : port_hi,
                         data_addr[DATA_W-1:0]};
            nxt.wdata = wr_data;
        end else if (fetch_ext) begin
            nxt.kind = CK_FETCH;
            nxt.addr = fetch_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       req <= '{kind: CK_IDLE, addr: '0, wdata: '0};
        else if (wrap) req <= nxt;
    end

endmodule

// File: rtl/ebs_strobe_dec.sv
module ebs_strobe_dec
    import ebs_pkg::*;
(
    input  cyc_kind_t kind,
    input  phase_t    ph,
    input  phase_t    hph,
    input  logic      upper,
    output logic      ale,
    output logic      psen_n,
    output logic      rd_n,
    output logic      wr_n
);

    logic data_cyc;

    always_comb begin
        data_cyc = is_data(kind);
        // latch pulse at the head of each half; a data cycle drops the second
        ale    = in_win(hph, 0, ALE_CLKS - 1) && !(data_cyc && upper);
        psen_n = !((kind == CK_FETCH) && in_win(hph, CODE_FIRST, CODE_LAST));
        rd_n   = !((kind == CK_DRD) && in_win(ph, STB_FIRST, STB_LAST));
        wr_n   = !((kind == CK_DWR) && in_win(ph, STB_FIRST, STB_LAST));
    end

endmodule

// File: rtl/ebs_bus_mux.sv
module ebs_bus_mux
    import ebs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cyc_req_t          req,
    input  phase_t            ph,
    input  phase_t            hph,
    input  logic              upper,
    input  logic [HI_W-1:0]   port_hi,
    input  logic [DATA_W-1:0] bus_lo_in,
    output logic [DATA_W-1:0] bus_lo_out,
    output logic              bus_lo_oe,
    output logic [HI_W-1:0]   bus_hi_out,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_valid
);

    logic [ADDR_W-1:0] cur_addr;
    logic              addr_ph;
    logic              wd_ph;
    logic              cap;

    always_comb begin
        // second code byte sits one address above the first
        cur_addr = req.addr
                 + ADDR_W'((req.kind == CK_FETCH) && upper);
        addr_ph  = ((req.kind == CK_FETCH) && in_win(hph, 0, ALE_CLKS - 1))
                || (is_data(req.kind) && in_win(ph, 0, ALE_CLKS - 1));
        wd_ph    = (req.kind == CK_DWR) && in_win(ph, WD_FIRST, WD_LAST);

        bus_lo_oe  = addr_ph || wd_ph;
        bus_lo_out = wd_ph ? req.wdata : cur_addr[DATA_W-1:0];
        bus_hi_out = (req.kind == CK_IDLE) ? port_hi
                                           : cur_addr[ADDR_W-1:DATA_W];

        // sample on the edge that ends the last low clock of a read strobe
        cap = ((req.kind == CK_FETCH) && in_win(hph, CODE_LAST, CODE_LAST))
           || ((req.kind == CK_DRD) && in_win(ph, STB_LAST, STB_LAST));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata       <= '0;
            rdata_valid <= 1'b0;
        end else begin
            rdata_valid <= cap;
            if (cap) rdata <= bus_lo_in;
        end
    end

endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
    import ebs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_ext,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              data_req,
    input  logic              data_we,
    input  logic              data_wide,
    input  logic [ADDR_W-1:0] data_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [HI_W-1:0]   port_hi,
    input  logic [DATA_W-1:0] bus_lo_in,
    output logic [DATA_W-1:0] bus_lo_out,
    output logic              bus_lo_oe,
    output logic [HI_W-1:0]   bus_hi_out,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_valid
);

    phase_t   ph;
    phase_t   hph;
    logic     upper;
    logic     wrap;
    cyc_req_t req;

    ebs_phase_gen i_phase (
        .clk   (clk),
        .rst   (rst),
        .ph    (ph),
        .hph   (hph),
        .upper (upper),
        .wrap  (wrap)
    );

    ebs_req_latch i_req (
        .clk        (clk),
        .rst        (rst),
        .wrap       (wrap),
        .fetch_ext  (fetch_ext),
        .fetch_addr (fetch_addr),
        .data_req   (data_req),
        .data_we    (data_we),
        .data_wide  (data_wide),
        .data_addr  (data_addr),
        .wr_data    (wr_data),
        .port_hi    (port_hi),
        .req        (req)
    );

    ebs_strobe_dec i_stb (
        .kind   (req.kind),
        .ph     (ph),
        .hph    (hph),
        .upper  (upper),
        .ale    (ale),
        .psen_n (psen_n),
        .rd_n   (rd_n),
        .wr_n   (wr_n)
    );

    ebs_bus_mux i_mux (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .ph          (ph),
        .hph         (hph),
        .upper       (upper),
        .port_hi     (port_hi),
        .bus_lo_in   (bus_lo_in),
        .bus_lo_out  (bus_lo_out),
        .bus_lo_oe   (bus_lo_oe),
        .bus_hi_out  (bus_hi_out),
        .rdata       (rdata),
        .rdata_valid (rdata_valid)
    );

endmodule

// File: rtl/ext_bus_seq_chk.sv
module ext_bus_seq_chk (
    input logic clk,
    input logic rst,
    input logic ale,
    input logic psen_n,
    input logic rd_n,
    input logic wr_n,
    input logic bus_lo_oe,
    input logic rdata_valid
);

    logic [3:0] code_low_run;
    logic [3:0] data_low_run;

    // length of the current low run of each strobe group
    always_ff @(posedge clk) begin
        if (rst) begin
            code_low_run <= '0;
            data_low_run <= '0;
        end else begin
            code_low_run <= psen_n ? 4'd0 : code_low_run + 4'd1;
            data_low_run <= (rd_n && wr_n) ? 4'd0 : data_low_run + 4'd1;
        end
    end

    a_r1_ale_rise_holds: assert property (@(posedge clk) disable iff (rst)
        $rose(ale) |=> ale);

    a_r1_ale_two_clocks: assert property (@(posedge clk) disable iff (rst)
        (ale && $past(ale)) |=> !ale);

    a_r3_code_after_ale: assert property (@(posedge clk) disable iff (rst)
        $fell(psen_n) |-> (!ale && $past(!ale) && $past(ale, 2)));

    a_r3_code_width: assert property (@(posedge clk) disable iff (rst)
        $rose(psen_n) |-> (code_low_run == 4'd3));

    a_r6_data_width: assert property (@(posedge clk) disable iff (rst)
        ($rose(rd_n) || $rose(wr_n)) |-> (data_low_run == 4'd6));

    a_r6_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $countones({!psen_n, !rd_n, !wr_n}) <= 1);

    a_r5_no_ale_in_strobe: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n) |-> !ale);

    a_r8_released_on_read: assert property (@(posedge clk) disable iff (rst)
        (!psen_n || !rd_n) |-> !bus_lo_oe);

    a_r8_driven_on_write: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> bus_lo_oe);

    a_r9_valid_after_release: assert property (@(posedge clk) disable iff (rst)
        rdata_valid |-> ($rose(psen_n) || $rose(rd_n)));

endmodule

bind ext_bus_seq ext_bus_seq_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .ale         (ale),
    .psen_n      (psen_n),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .bus_lo_oe   (bus_lo_oe),
    .rdata_valid (rdata_valid)
);

// File: tb/test_ext_bus_seq.sv
module test_ext_bus_seq;
    import ebs_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int N_VEC      = 10;

    // {both[35], kind[34:33] 0 idle 1 code 2 read 3 write, wide[32],
    //  addr[31:16], wdata[15:8], port[7:0]}
    localparam logic [35:0] VEC [N_VEC] = '{
        {1'b0, 2'd1, 1'b0, 16'h1234, 8'h00, 8'hA5},
        {1'b0, 2'd2, 1'b1, 16'hABCD, 8'h00, 8'h3C},
        {1'b0, 2'd3, 1'b0, 16'h0055, 8'hE7, 8'h7E},
        {1'b0, 2'd0, 1'b0, 16'h0000, 8'h00, 8'h96},
        {1'b0, 2'd1, 1'b0, 16'h12FF, 8'h00, 8'h11},
        {1'b1, 2'd2, 1'b0, 16'h4321, 8'h00, 8'hC8},
        {1'b1, 2'd3, 1'b1, 16'h8001, 8'h5B, 8'h22},
        {1'b0, 2'd1, 1'b0, 16'hFFFF, 8'h00, 8'h44},
        {1'b0, 2'd2, 1'b0, 16'h00F0, 8'h00, 8'h0F},
        {1'b0, 2'd0, 1'b0, 16'h0000, 8'h00, 8'h00}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_ext = 1'b0;
    logic [15:0] fetch_addr = '0;
    logic        data_req = 1'b0;
    logic        data_we = 1'b0;
    logic        data_wide = 1'b0;
    logic [15:0] data_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  port_hi = '0;
    logic [7:0]  bus_lo_in;
    logic [7:0]  bus_lo_out;
    logic        bus_lo_oe;
    logic [7:0]  bus_hi_out;
    logic        ale, psen_n, rd_n, wr_n;
    logic [7:0]  rdata;
    logic        rdata_valid;

    int n_chk = 0;
    int n_bad = 0;
    logic        prev_code = 1'b0;
    logic [15:0] prev_addr = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ext_bus_seq i_ext_bus_seq (.*);

    // behavioural memory behind an external low-address latch
    function automatic logic [7:0] mem_fn(input logic [15:0] a);
        return a[7:0] ^ (a[15:8] * 8'd3) ^ 8'h5A;
    endfunction

    logic [7:0] lat_lo = '0;
    always @(negedge clk) if (ale && bus_lo_oe) lat_lo <= bus_lo_out;
    assign bus_lo_in = mem_fn({bus_hi_out, lat_lo});

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic apply(input logic [35:0] v);
        int k;
        k          = int'(v[34:33]);
        data_req   = (k >= 2);
        fetch_ext  = (k == 1) || v[35];
        data_we    = (k == 3);
        data_wide  = v[32];
        fetch_addr = v[31:16];
        data_addr  = v[31:16];
        wr_data    = v[15:8];
        port_hi    = v[7:0];
    endtask

    // one machine cycle; entered at the negedge inside phase 11
    task automatic run_cycle(input logic [35:0] v);
        int          k;
        logic [15:0] a;
        logic [15:0] fa;
        logic [7:0]  ehi;
        logic        e_ale, e_oe, e_val;
        logic [7:0]  e_lo, e_rd;
        k = int'(v[34:33]);
        a = v[31:16];
        apply(v);
        for (int p = 0; p < MC_CLKS; p++) begin
            @(posedge clk);
            @(negedge clk);
            fa    = (k == 1) ? a + 16'(p >= 6) : a;
            e_ale = ((p % 6) < 2) && !((k >= 2) && (p >= 6));
            chk((k >= 2 && p >= 6) ? "R5 ale skipped" : "R1 ale", 16'(ale), 16'(e_ale));
            chk(k >= 2 ? "R5 code strobe idle" : "R3 code strobe",
                16'(psen_n), 16'(!((k == 1) && ((p % 6) >= 3))));
            chk(v[35] ? "R2 priority rd_n" : "R6 rd_n",
                16'(rd_n), 16'(!((k == 2) && p >= 5 && p <= 10)));
            chk(v[35] ? "R2 priority wr_n" : "R6 wr_n",
                16'(wr_n), 16'(!((k == 3) && p >= 5 && p <= 10)));
            e_oe = ((k == 1) && (p % 6) < 2) || ((k >= 2) && p < 2) || ((k == 3) && p >= 2);
            chk("R8 lo drive enable", 16'(bus_lo_oe), 16'(e_oe));
            if (e_oe) begin
                e_lo = ((k == 3) && p >= 2) ? v[15:8] : fa[7:0];
                chk(k == 1 ? "R4 code lo addr" : "R8 lo byte", 16'(bus_lo_out), 16'(e_lo));
            end
            ehi = (k == 1) ? fa[15:8] : ((k >= 2) && v[32]) ? a[15:8] : v[7:0];
            chk(k == 1 ? "R4 code hi addr" : "R7 hi byte", 16'(bus_hi_out), 16'(ehi));
            e_val = (p == 0 && prev_code) || (k == 1 && p == 6) || (k == 2 && p == 11);
            chk("R9 rdata_valid", 16'(rdata_valid), 16'(e_val));
            if (e_val) begin
                if (p == 0)      e_rd = mem_fn(prev_addr + 16'd1);
                else if (k == 1) e_rd = mem_fn(a);
                else             e_rd = mem_fn({v[32] ? a[15:8] : v[7:0], a[7:0]});
                chk("R9 rdata", 16'(rdata), 16'(e_rd));
            end
        end
        prev_code = (k == 1);
        prev_addr = a;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2 reset state
        chk("R2 reset ale", 16'(ale), 16'd0);
        chk("R2 reset strobes", 16'({psen_n, rd_n, wr_n}), 16'b111);
        chk("R2 reset oe", 16'(bus_lo_oe), 16'd0);
        chk("R2 reset valid", 16'(rdata_valid), 16'd0);
        rst = 1'b0;

        for (int i = 0; i < N_VEC; i++) run_cycle(VEC[i]);

        // R2 reset in the middle of a code cycle
        apply({1'b0, 2'd1, 1'b0, 16'h2468, 8'h00, 8'h00});
        repeat (5) begin
            @(posedge clk);
            @(negedge clk);
        end
        chk("R3 code strobe before reset", 16'(psen_n), 16'd0);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R2 mid reset ale", 16'(ale), 16'd0);
        chk("R2 mid reset strobes", 16'({psen_n, rd_n, wr_n}), 16'b111);
        chk("R2 mid reset oe", 16'(bus_lo_oe), 16'd0);
        chk("R2 mid reset valid", 16'(rdata_valid), 16'd0);
        prev_code = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        // R1 idle cycle after reset still pulses ale at the steady rate
        run_cycle({1'b0, 2'd0, 1'b0, 16'h0000, 8'h00, 8'h5D});
        finish_run();
    end

endmodule